// File: doc/BRIEF.md
# MDIO Management Frame Slave

This block is the serial end of a Clause-22-style station management port. It is clocked by the management clock (MDC). It samples the shared MDIO line on every rising edge and picks out the preamble and the start pattern. It then decodes the opcode, the device address and the register address, and compares the device address with the value on `phy_addr`. A matching read fetches one word from an attached register bank and shifts it back onto the line. A matching write collects a word from the line and hands it to the bank with a one-cycle strobe.

After reset the block needs one full run of 32 ones on the line before it will accept a start pattern. From then on a frame may open with the start pattern directly, as long as at least one idle (high) bit separates it from the previous frame. Frames with an unknown opcode or a foreign address are followed bit by bit to their end, so the block never loses its place in the frame. These frames never drive the line and never raise a strobe.

The register-bank side is a plain strobe interface and has no valid/ready handshake. The line timing is fixed by the master, so the block cannot apply back-pressure. The bank must accept a write strobe in the cycle it appears. After a read strobe, the bank must hold `reg_rdata` valid for the address on `reg_addr` from the next cycle until the second cycle after the strobe.

Top module: `mdio_slave`

## Requirements
- R1: While `rst_n` is low, and after it is released until a frame is accepted, `mdio_oe`, `reg_wr` and `reg_rd` are 0.
- R2: After reset, a 0 on the line counts as a start only if it follows at least 32 consecutive 1s sampled while idle; 31 ones are not enough.
- R3: Once 32 ones have been seen, a single idle 1 before the start pattern is enough. A 0 sampled in the bit directly after the last data bit of a frame is not taken as a start.
- R4: The opcode bits 10 (read) and 01 (write), first bit first, are the only ones acted on. A frame with opcode 00 or 11 drives nothing and raises no strobe.
- R5: The 5-bit device address, sent MSB first, must equal `phy_addr`. Otherwise the frame drives nothing and raises no strobe, and the bank keeps its contents.
- R6: On a matching read, `reg_rd` is high for exactly one cycle, right after the last register address bit (MSB first) is sampled, with `reg_addr` valid.
- R7: On a matching read, `mdio_oe` stays low for the first turnaround bit and goes high with `mdio_o` = 0 for the second.
- R8: Read data is driven MSB first, one bit per MDC rising edge, for 16 bits. `mdio_oe` falls at the edge that ends the last data bit, so the line is driven for exactly 17 bit times.
- R9: On a matching write, `reg_wr` is high for one cycle after the 16th data bit is sampled, with `reg_wdata` (MSB first on the line) and `reg_addr`. The line is never driven during a write.
- R10: The first data bit driven is bit 15 of `reg_rdata`, sampled at the edge that ends the second turnaround bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock (MDC); everything happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr | input | 5 | Device address this slave answers to |
| mdio_i | input | 1 | Sampled level of the shared MDIO line |
| mdio_o | output | 1 | Level driven onto MDIO when enabled |
| mdio_oe | output | 1 | Drive enable for MDIO; low leaves the line to the pull-up |
| reg_addr | output | 5 | Register address of the current accepted access |
| reg_wdata | output | 16 | Write data, valid with `reg_wr` |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 16 | Read data from the bank, sampled the cycle after `reg_rd` |

## Verification
A wrong bit count or a wrong field boundary inside the decoder shows at the ports in the same frame. The strobe appears one or more bit times early or late, or `mdio_oe` rises at the wrong edge, or the read data comes back shifted by a bit. A mistake in the preamble tracker can stay hidden until the next start pattern. It then shows as a frame that is accepted when it should be refused, or refused when it should be accepted, and the bench sees the strobe or the drive enable differ within about 14 bit times of that start. Because the reference model checks every output on every MDC cycle, a fault is caught at the first edge where the outputs diverge, not at the end of the test.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_OP,
    ST_PHY,
    ST_REG,
    ST_TA,
    ST_DATA
  } frame_st_e;

  localparam int OP_W = 2;
  localparam int TA_W = 2;
  localparam logic [OP_W-1:0] OP_READ  = 2'b10;
  localparam logic [OP_W-1:0] OP_WRITE = 2'b01;

endpackage

// File: rtl/mdio_preamble_tracker.sv
module mdio_preamble_tracker #(
  parameter int PRE_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_idle,
  input  logic bit_in,
  output logic sof
);
  localparam int CW = $clog2(PRE_LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(PRE_LEN);

  logic [CW-1:0] run_q;
  logic          seen_q;

  // Count consecutive ones sampled while idle, saturating at a full preamble.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      seen_q <= 1'b0;
    end else if (!in_idle || !bit_in) begin
      run_q <= '0;
    end else begin
      if (run_q != FULL) run_q <= run_q + 1'b1;
      if (run_q >= FULL - 1'b1) seen_q <= 1'b1;
    end
  end

  // A zero while idle opens a frame after a full preamble, or after
  // at least one idle bit once a full preamble has been seen.
  assign sof = in_idle && !bit_in &&
               ((run_q == FULL) || (seen_q && (run_q != '0)));

endmodule

// File: rtl/mdio_frame_decoder.sv
module mdio_frame_decoder
  import mdio_slv_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  input  logic              sof,
  input  logic [ADDR_W-1:0] phy_addr,
  output logic              in_idle,
  output logic              ta_first,
  output logic              ta_second,
  output logic              data_step,
  output logic              data_last,
  output logic              rd_act,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd
);
  localparam int HDR_W = OP_W + 2 * ADDR_W;
  localparam int CW    = $clog2(DATA_W) + 1;

  frame_st_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [HDR_W-2:0]  hdr_q;
  logic [DATA_W-2:0] wsh_q;
  logic              wr_act_q;
  logic              rd_act_q;

  logic [HDR_W-1:0]  hdr_full;
  logic [OP_W-1:0]   f_op;
  logic [ADDR_W-1:0] f_phy;
  logic [ADDR_W-1:0] f_reg;
  logic              f_match;

  function automatic logic [CW-1:0] last_idx(input frame_st_e s);
    case (s)
      ST_OP:          return CW'(OP_W - 1);
      ST_PHY, ST_REG: return CW'(ADDR_W - 1);
      ST_TA:          return CW'(TA_W - 1);
      ST_DATA:        return CW'(DATA_W - 1);
      default:        return '0;
    endcase
  endfunction

  assign hdr_full = {hdr_q, bit_in};
  assign f_op     = hdr_full[HDR_W-1 -: OP_W];
  assign f_phy    = hdr_full[2*ADDR_W-1 -: ADDR_W];
  assign f_reg    = hdr_full[ADDR_W-1:0];
  assign f_match  = (f_phy == phy_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      hdr_q     <= '0;
      wsh_q     <= '0;
      wr_act_q  <= 1'b0;
      rd_act_q  <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (sof) state_q <= ST_START;
        end
        ST_START: begin
          cnt_q   <= '0;
          state_q <= bit_in ? ST_OP : ST_IDLE;
        end
        default: begin
          if (state_q inside {ST_OP, ST_PHY, ST_REG})
            hdr_q <= {hdr_q[HDR_W-3:0], bit_in};
          if (state_q == ST_DATA)
            wsh_q <= {wsh_q[DATA_W-3:0], bit_in};
          if (cnt_q == last_idx(state_q)) begin
            cnt_q <= '0;
            case (state_q)
              ST_OP:  state_q <= ST_PHY;
              ST_PHY: state_q <= ST_REG;
              ST_REG: begin
                state_q  <= ST_TA;
                rd_act_q <= f_match && (f_op == OP_READ);
                wr_act_q <= f_match && (f_op == OP_WRITE);
                reg_rd   <= f_match && (f_op == OP_READ);
                if (f_match && (f_op == OP_READ || f_op == OP_WRITE))
                  reg_addr <= f_reg;
              end
              ST_TA:  state_q <= ST_DATA;
              default: begin
                state_q  <= ST_IDLE;
                rd_act_q <= 1'b0;
                wr_act_q <= 1'b0;
                if (wr_act_q) begin
                  reg_wr    <= 1'b1;
                  reg_wdata <= {wsh_q, bit_in};
                end
              end
            endcase
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign in_idle   = (state_q == ST_IDLE);
  assign ta_first  = (state_q == ST_TA) && (cnt_q == '0);
  assign ta_second = (state_q == ST_TA) && (cnt_q == CW'(TA_W - 1));
  assign data_step = (state_q == ST_DATA);
  assign data_last = (state_q == ST_DATA) && (cnt_q == CW'(DATA_W - 1));
  assign rd_act    = rd_act_q;

endmodule

// File: rtl/mdio_read_driver.sv
module mdio_read_driver #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_act,
  input  logic              ta_first,
  input  logic              ta_second,
  input  logic              data_step,
  input  logic              data_last,
  input  logic [DATA_W-1:0] rdata,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic [DATA_W-2:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      sh_q    <= '0;
    end else if (rd_act) begin
      if (ta_first) begin
        mdio_oe <= 1'b1;
        mdio_o  <= 1'b0;
      end else if (ta_second) begin
        mdio_o <= rdata[DATA_W-1];
        sh_q   <= rdata[DATA_W-2:0];
      end else if (data_step) begin
        if (data_last) begin
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b0;
        end else begin
          mdio_o <= sh_q[DATA_W-2];
          sh_q   <= {sh_q[DATA_W-3:0], 1'b0};
        end
      end
    end
  end

endmodule

// File: rtl/mdio_slave.sv
module mdio_slave #(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata
);
  logic in_idle, sof;
  logic ta_first, ta_second, data_step, data_last, rd_act;

  mdio_preamble_tracker #(.PRE_LEN(PRE_LEN)) u_pre (
    .clk(clk), .rst_n(rst_n), .in_idle(in_idle), .bit_in(mdio_i), .sof(sof)
  );

  mdio_frame_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .bit_in(mdio_i), .sof(sof), .phy_addr(phy_addr),
    .in_idle(in_idle), .ta_first(ta_first), .ta_second(ta_second),
    .data_step(data_step), .data_last(data_last), .rd_act(rd_act),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd)
  );

  mdio_read_driver #(.DATA_W(DATA_W)) u_drv (
    .clk(clk), .rst_n(rst_n), .rd_act(rd_act), .ta_first(ta_first),
    .ta_second(ta_second), .data_step(data_step), .data_last(data_last),
    .rdata(reg_rdata), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

endmodule

// File: rtl/mdio_slave_checker.sv
module mdio_slave_checker #(
  parameter int DATA_W = 16
) (
  input logic clk,
  input logic rst_n,
  input logic mdio_o,
  input logic mdio_oe,
  input logic reg_wr,
  input logic reg_rd
);
  logic [7:0] span_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) span_q <= '0;
    else if (mdio_oe) span_q <= span_q + 1'b1;
    else span_q <= '0;
  end

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd); // R6
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr); // R9
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr)); // R4
  AST_TA1_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> !mdio_oe); // R7
  AST_TA2_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o); // R7
  AST_DRIVE_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> $past(reg_rd)); // R6
  AST_WRITE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !mdio_oe); // R9
  AST_DRIVE_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdio_oe) |-> (span_q == 8'(DATA_W + 1))); // R8

endmodule

bind mdio_slave mdio_slave_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .reg_wr(reg_wr), .reg_rd(reg_rd)
);

// File: tb/mdio_slave_test.sv
module mdio_slave_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  phy_addr = 5'h05;
  logic        m_drive = 1'b1;
  logic        m_val = 1'b1;
  logic        mdio_o, mdio_oe, reg_wr, reg_rd;
  logic [4:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        line;
  logic [15:0] bank [32];
  logic [15:0] shadow [32];
  int          n_cmp = 0;
  int          n_bad = 0;
  int          run = 0;
  bit          seen = 0;

  always #10 clk = ~clk;

  assign line = mdio_oe ? mdio_o : (m_drive ? m_val : 1'b1);
  assign reg_rdata = bank[reg_addr];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) bank[i] <= 16'(i * 257);
    end else if (reg_wr) begin
      bank[reg_addr] <= reg_wdata;
    end
  end

  mdio_slave uut (
    .clk(clk), .rst_n(rst_n), .phy_addr(phy_addr), .mdio_i(line),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata)
  );

  task automatic compare(input logic e_oe, input logic e_o, input logic e_wr,
                         input logic e_rd, input logic [4:0] e_addr,
                         input logic [15:0] e_wd, input string tag);
    bit bad;
    n_cmp++;
    bad = (mdio_oe !== e_oe) || (e_oe && mdio_o !== e_o) ||
          (reg_wr !== e_wr) || (reg_rd !== e_rd) ||
          ((e_wr || e_rd) && reg_addr !== e_addr) ||
          (e_wr && reg_wdata !== e_wd);
    if (bad) begin
      n_bad++;
      $display("FAIL %s t=%0t: oe=%b o=%b wr=%b rd=%b addr=%h wd=%h / expected oe=%b o=%b wr=%b rd=%b addr=%h wd=%h",
               tag, $time, mdio_oe, mdio_o, reg_wr, reg_rd, reg_addr, reg_wdata,
               e_oe, e_o, e_wr, e_rd, e_addr, e_wd);
    end
  endtask

  // Drive one bit time, then check the outputs after the edge that samples it.
  task automatic tick(input logic drv, input logic b, input logic e_oe,
                      input logic e_o, input logic e_wr, input logic e_rd,
                      input logic [4:0] e_addr, input logic [15:0] e_wd,
                      input string tag);
    m_drive = drv;
    m_val   = b;
    @(posedge clk);
    @(negedge clk);
    compare(e_oe, e_o, e_wr, e_rd, e_addr, e_wd, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      tick(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'h0, 16'h0, tag);
      run++;
      if (run >= 32) seen = 1;
    end
  endtask

  task automatic frame(input int pre, input logic [1:0] op, input logic [4:0] phy,
                       input logic [4:0] ra, input logic [15:0] d, input string tag);
    bit acc, isrd, iswr, mdrv;
    logic [15:0] rexp;
    logic [11:0] hdr;
    idle(pre, tag);
    acc  = (run >= 32) || (seen && run >= 1);
    isrd = acc && (phy == phy_addr) && (op == 2'b10);
    iswr = acc && (phy == phy_addr) && (op == 2'b01);
    mdrv = (op != 2'b10);
    rexp = shadow[ra];
    hdr  = {op, phy, ra};
    tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'h0, 16'h0, tag);
    tick(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'h0, 16'h0, tag);
    for (int i = 11; i >= 0; i--)
      tick(1'b1, hdr[i], 1'b0, 1'b0, 1'b0, (i == 0) && isrd, ra, 16'h0,
           (i == 0 && isrd) ? "R6" : tag);
    tick(mdrv, 1'b1, isrd, 1'b0, 1'b0, 1'b0, ra, 16'h0, isrd ? "R7" : tag);
    tick(mdrv, 1'b0, isrd, rexp[15], 1'b0, 1'b0, ra, 16'h0, isrd ? "R10" : tag);
    for (int i = 0; i < 16; i++) begin
      if (i < 15)
        tick(mdrv, d[15-i], isrd, rexp[14-i], 1'b0, 1'b0, ra, 16'h0,
             isrd ? "R8" : tag);
      else
        tick(mdrv, d[0], 1'b0, 1'b0, iswr, 1'b0, ra, d,
             iswr ? "R9" : (isrd ? "R8" : tag));
    end
    if (iswr) shadow[ra] = d;
    run = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete / expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) shadow[i] = 16'(i * 257);
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare(1'b0, 1'b0, 1'b0, 1'b0, 5'h0, 16'h0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare(1'b0, 1'b0, 1'b0, 1'b0, 5'h0, 16'h0, "R1");
    // R2: no preamble, then only 31 ones: both refused
    frame(1, 2'b01, 5'h05, 5'h03, 16'h1234, "R2");
    frame(31, 2'b10, 5'h05, 5'h03, 16'h0000, "R2");
    // R2: full preamble accepted (write)
    frame(32, 2'b01, 5'h05, 5'h03, 16'hA5C3, "R2");
    // R3: preamble suppressed, one idle bit
    frame(1, 2'b10, 5'h05, 5'h03, 16'h0000, "R3");
    // R5: foreign address, write then read
    frame(1, 2'b01, 5'h06, 5'h03, 16'hFFFF, "R5");
    frame(1, 2'b10, 5'h06, 5'h03, 16'h0000, "R5");
    // R4: unknown opcodes
    frame(1, 2'b11, 5'h05, 5'h03, 16'h0000, "R4");
    frame(1, 2'b00, 5'h05, 5'h03, 16'h0000, "R4");
    frame(1, 2'b10, 5'h05, 5'h03, 16'h0000, "R4");
    // R9/R8: another register, back to back with one idle bit
    frame(1, 2'b01, 5'h05, 5'h1F, 16'h8001, "R9");
    frame(1, 2'b10, 5'h05, 5'h1F, 16'h0000, "R8");
    // R3: write with no idle bit after the previous frame is refused
    frame(0, 2'b01, 5'h05, 5'h03, 16'h0F0F, "R3");
    idle(4, "R3");
    frame(1, 2'b10, 5'h05, 5'h03, 16'h0000, "R3");
    // R5: new programmed address
    phy_addr = 5'h1A;
    frame(1, 2'b01, 5'h1A, 5'h07, 16'h5A5A, "R5");
    frame(1, 2'b10, 5'h1A, 5'h07, 16'h0000, "R5");
    frame(1, 2'b10, 5'h05, 5'h07, 16'h0000, "R5");
    frame(1, 2'b10, 5'h1A, 5'h00, 16'h0000, "R8");
    idle(3, "R1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule